// File: doc/BRIEF.md
# Lock-Step Shift-Register Channel Buffer

This block sits on a valid/ready channel and adds a fixed number of register stages between producer and consumer. Each stage holds one data word and a flag that marks it as occupied. All stages are moved by one common enable. When the enable is high, every stage takes the contents of the stage before it, and the first stage takes the current input word and its valid flag. When the enable is low, every stage holds. No stage accepts or stalls on its own.

The enable is high whenever the final stage is empty or the consumer is ready. That same signal is returned upstream as the input ready, with no register on the way. Data and valid each pass through one register per stage. Ready passes straight through.

Empty slots are not squeezed out. A cycle in which the chain moves while no input is offered leaves a bubble, and that bubble travels down the chain like a token. The stage count is a parameter of this single module, so deeper buffering does not need a chain of instances.

Top module: `shreg_buffer`

## Requirements
- R1: While reset is asserted and right after it is released, out_valid is 0 and in_ready is 1.
- R2: in_ready has no register on its path. In every cycle it is 1 exactly when out_valid is 0 or out_ready is 1.
- R3: If out_valid is 1 and out_ready is 0 at a clock edge, then in the next cycle out_valid is still 1 and out_data is unchanged.
- R4: Words leave in the order they were accepted. None is lost and none is duplicated. A word is accepted when in_valid and in_ready are both 1 at a clock edge, and delivered when out_valid and out_ready are both 1.
- R5: If the chain moves at every edge, a word accepted at one edge is offered on out_valid exactly DEPTH cycles later, one cycle per stage.
- R6: If the chain moves at every edge, the output reproduces the valid pattern of the input, gaps included, delayed by DEPTH cycles.
- R7: While in_ready is 0, in_valid and in_data have no effect. No word offered during that time is captured.
- R8: Bubbles are not collapsed. Starting from empty with out_ready held at 0, an unbroken stream is accepted exactly DEPTH times before in_ready drops. A single idle cycle inside the stream cuts the number accepted to DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low, clears all stage flags |
| in_data | input | W | Data word from the producer |
| in_valid | input | 1 | Producer offers in_data |
| in_ready | output | 1 | Shared shift enable, returned to the producer |
| out_data | output | W | Data word from the final stage |
| out_valid | output | 1 | Final stage is occupied |
| out_ready | input | 1 | Consumer can take out_data |

## Verification
The bench fills the chain from empty with the consumer stalled, once with an unbroken stream and once with a one-cycle gap. A design that compacted bubbles would accept DEPTH words in the second case, and one that let the chain run past a full final stage would accept more than DEPTH in the first. It then streams words with gaps while the consumer is always ready, and checks the exact delay and the shape of the gaps at the output. A stage missing or added would show as a latency other than DEPTH, and a bubble dropped would show as a changed gap pattern. Finally, a long stream under an irregular out_ready pattern checks order and completeness. A ready path with a register, or a chain that moved while stalled, would show up as lost, duplicated or changed words, or as a held output that does not stay put.

// File: rtl/shreg_buffer.sv
module shreg_buffer #(
  parameter int W     = 8,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  output logic         in_ready,
  output logic [W-1:0] out_data,
  output logic         out_valid,
  input  logic         out_ready
);

  localparam int LAST = DEPTH - 1;

  generate
    if (DEPTH < 1) begin : g_depth_check
      $error("shreg_buffer: DEPTH must be at least 1");
    end
  endgenerate

  logic [DEPTH-1:0] vld_q;
  logic [W-1:0]     dat_q [DEPTH];
  logic             shift;

  assign shift     = ~vld_q[LAST] | out_ready;
  assign in_ready  = shift;
  assign out_valid = vld_q[LAST];
  assign out_data  = dat_q[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (shift) begin
      for (int k = LAST; k > 0; k--) vld_q[k] <= vld_q[k-1];
      vld_q[0] <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (shift) begin
      for (int k = LAST; k > 0; k--) dat_q[k] <= dat_q[k-1];
      dat_q[0] <= in_data;
    end
  end

  a_r3_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r7_frozen_when_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(vld_q) && $stable(out_data));

  a_r6_token_enters: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> vld_q[0]);

  a_r6_bubble_enters: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && in_ready |=> !vld_q[0]);

  a_r2_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

endmodule

// File: tb/sim_shreg_buffer.sv
`timescale 1ns/1ps
module sim_shreg_buffer;
  localparam int W = 8;
  localparam int DEPTH = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic [W-1:0] in_data = '0;
  logic in_valid = 0;
  logic in_ready;
  logic [W-1:0] out_data;
  logic out_valid;
  logic out_ready = 0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int accepted = 0;
  bit lat_mode = 0;
  int lat_start = 0;
  bit hist [64];
  bit prev_stall = 0;
  logic [W-1:0] prev_data = '0;
  bit done = 0;

  logic [W-1:0] exp_q [$];
  int cyc_q [$];

  shreg_buffer #(.W(W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      check(in_ready == (!out_valid || out_ready), "R2", in_ready, !out_valid || out_ready);
      if (prev_stall) begin
        check(out_valid == 1'b1, "R3 valid held", out_valid, 1);
        check(out_data == prev_data, "R3 data held", out_data, prev_data);
      end
      if (lat_mode && cyc >= lat_start + DEPTH)
        check(out_valid == hist[(cyc - DEPTH) % 64], "R6 gap pattern", out_valid, hist[(cyc - DEPTH) % 64]);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R4 unexpected word", out_data, -1);
        end else begin
          logic [W-1:0] e;
          int c;
          e = exp_q.pop_front();
          c = cyc_q.pop_front();
          check(out_data == e, "R4 order", out_data, e);
          if (lat_mode) check(cyc - c == DEPTH, "R5 latency", cyc - c, DEPTH);
        end
      end
      if (lat_mode) hist[cyc % 64] = in_valid && in_ready;
      if (in_valid && in_ready) begin
        exp_q.push_back(in_data);
        cyc_q.push_back(cyc);
        accepted++;
      end
      prev_stall = out_valid && !out_ready;
      prev_data = out_data;
    end
    cyc++;
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic put(input logic [W-1:0] d);
    in_valid = 1; in_data = d;
    do @(negedge clk); while (!in_ready);
    step();
    in_valid = 0;
  endtask

  task automatic stream(input int n, input logic [W-1:0] base);
    logic [W-1:0] d;
    d = base;
    in_valid = 1; in_data = d;
    repeat (n) begin
      @(negedge clk);
      if (in_ready) d++;
      step();
      in_data = d;
    end
    in_valid = 0;
  endtask

  initial begin
    int a0;
    logic [7:0] lfsr;
    step(); step();
    check(out_valid == 0, "R1 out_valid in reset", out_valid, 0);
    check(in_ready == 1, "R1 in_ready in reset", in_ready, 1);
    rst_n = 1;
    step();
    check(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1, "R1 in_ready after reset", in_ready, 1);

    // R5 / R6: free-running flow with gaps
    out_ready = 1;
    for (int i = 0; i < 64; i++) hist[i] = 0;
    lat_start = cyc;
    lat_mode = 1;
    put(8'h01); put(8'h02); step(); put(8'h03); step(); step();
    put(8'h04); put(8'h05); step(); put(8'h06);
    repeat (DEPTH + 4) step();
    lat_mode = 0;

    // R8 / R7: fill from empty, no gap, consumer stalled
    out_ready = 0;
    a0 = accepted;
    stream(10, 8'h10);
    check(accepted - a0 == DEPTH, "R8 full-stream capacity", accepted - a0, DEPTH);
    in_valid = 1; in_data = 8'hEE;
    repeat (4) step();
    check(accepted - a0 == DEPTH, "R7 input ignored while stalled", accepted - a0, DEPTH);
    check(out_data == 8'h10, "R7 head word kept", out_data, 8'h10);
    in_valid = 0;
    out_ready = 1;
    repeat (DEPTH + 3) step();

    // R8: one idle cycle in the stream
    out_ready = 0;
    a0 = accepted;
    put(8'h20); step(); stream(6, 8'h21);
    check(accepted - a0 == DEPTH - 1, "R8 bubble not collapsed", accepted - a0, DEPTH - 1);
    out_ready = 1;
    repeat (DEPTH + 3) step();

    // R4: long stream with irregular consumer
    lfsr = 8'hA5;
    fork
      stream(80, 8'h40);
      repeat (90) begin
        out_ready = lfsr[0] | lfsr[3];
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        step();
      end
    join
    out_ready = 1;
    repeat (DEPTH + 4) step();
    check(exp_q.size() == 0, "R4 all words delivered", exp_q.size(), 0);
    check(!out_valid, "R4 chain empty at end", out_valid, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule